// File: doc/BRIEF.md
# Multiprocessor Device Interrupt Router

This block collects device interrupt events for 64 lines into one shared pending register and hands them out to up to four processors. Every processor owns a 64-bit enable mask. The block keeps a routed register per processor that always holds that processor's mask ANDed with the shared pending register. A processor's interrupt output stays high while its routed register is nonzero. Alongside it, the block reports the lowest routed line number as a priority hint.

Devices signal through two pulse vectors, one that raises lines and one that drops them. A simple 64-bit request/response port gives access to the state. Software writes the masks through this port. It reads back the masks, the routed registers and the pending register, and each access is answered one cycle later.

The register index is the byte address shifted right by six. Index 0 to 3 selects the enable mask of processor 0 to 3. Index 4 to 7 selects the routed register of processor 0 to 3. Index 8 selects the pending register. Only 64-bit accesses are legal.

Top module: `dev_irq_router`

## Requirements
- R1: After reset, every mask, routed and pending register reads zero, all `cpu_irq` bits are low, every `cpu_line` field is zero and `resp_valid` is low.
- R2: A `dev_set` bit sets its pending bit and a `dev_clr` bit clears it, taking effect at the next clock edge; when both pulse for the same line in one cycle, the set wins.
- R3: A `dev_clr` pulse on a line whose pending bit is already zero changes no register and no output.
- R4: Each processor's routed register equals its mask ANDed with the pending register after every edge. This includes the edge where a mask write and a device event land in the same cycle, so both are reflected at once.
- R5: `cpu_irq[c]` is high exactly when routed register c is nonzero. `cpu_line[6c+5:6c]` gives the lowest set bit index of that register, or zero when it is empty.
- R6: The register index is `req_addr >> 6`, so address bits 5:0 are ignored. Index 0..3 selects a mask, 4..7 a routed register and 8 the pending register.
- R7: A legal write to a mask index replaces the whole mask, and the mask reads back unchanged until the next write to it.
- R8: A write to a routed register or to the pending register returns `resp_err` high and changes no state.
- R9: An access whose `req_size` is not 3 (code 3 means 8 bytes) returns `resp_err` high with zero read data and changes no state.
- R10: An access to an index above 8 returns `resp_err` high with zero read data.
- R11: Every request with `req_valid` high is answered by `resp_valid` high in the following cycle only. The read data reflect state before the edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dev_set | input | 64 | Per-line raise pulses |
| dev_clr | input | 64 | Per-line drop pulses |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address; index = addr >> 6 |
| req_size | input | 2 | Access size code, 3 = 8 bytes |
| req_wdata | input | 64 | Write data |
| resp_valid | output | 1 | Response strobe, one cycle after request |
| resp_err | output | 1 | Error response |
| resp_rdata | output | 64 | Read data, zero on error or write |
| cpu_irq | output | 4 | Per-processor interrupt |
| cpu_line | output | 24 | Per-processor lowest routed line, 6 bits each |

## Verification
A mask write and a device event can land on the same clock edge, and the routed register must then combine the new mask with the new pending value. The bench provokes this in two ways. In one, it writes a mask that enables a line in the same cycle that line is raised. In the other, it writes a mask that moves enables away from one line and onto another while that first line drops and the second rises. It judges the result from `cpu_irq`, `cpu_line` and a read of the routed register, all compared with a model of the pending and mask state kept in the bench.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE   = 2'd0,
    SZ_HALF   = 2'd1,
    SZ_WORD   = 2'd2,
    SZ_DOUBLE = 2'd3
  } acc_size_e;

  localparam int unsigned IDX_SHIFT = 6;
endpackage

// File: rtl/rtr_pending_reg.sv
module rtr_pending_reg #(
  parameter int unsigned NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] dev_set,
  input  logic [NUM_LINES-1:0] dev_clr,
  output logic [NUM_LINES-1:0] pend_d,
  output logic [NUM_LINES-1:0] pend_q
);
  // set has priority over a drop in the same cycle; drop of a zero bit is a no-op
  always_comb begin
    pend_d = (pend_q & ~dev_clr) | dev_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(dev_set)) == $past(dev_set)));  // R2
  AST_SPURIOUS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(~pend_q & ~dev_set)) == '0));  // R3
endmodule

// File: rtl/rtr_cpu_slice.sv
module rtr_cpu_slice #(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mask_we,
  input  logic [NUM_LINES-1:0] wdata,
  input  logic [NUM_LINES-1:0] pend_d,
  input  logic [NUM_LINES-1:0] pend_q,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] route_q,
  output logic                 irq,
  output logic [LINE_W-1:0]    line
);
  logic [NUM_LINES-1:0] mask_d;
  logic [NUM_LINES-1:0] route_d;

  function automatic logic [LINE_W-1:0] lowest_set(input logic [NUM_LINES-1:0] v);
    logic [LINE_W-1:0] idx;
    idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (v[i]) idx = LINE_W'(i);
    end
    return idx;
  endfunction

  // routed value is built from next-state operands so both changes land together
  always_comb begin
    mask_d  = mask_we ? wdata : mask_q;
    route_d = mask_d & pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      route_q <= '0;
    end else begin
      if (mask_we) begin
        mask_q <= mask_d;
      end
      route_q <= route_d;
    end
  end

  always_comb begin
    irq  = |route_q;
    line = lowest_set(route_q);
  end

  AST_ROUTE_IS_AND: assert property (@(posedge clk) disable iff (!rst_n)
    route_q == (mask_q & pend_q));  // R4
  AST_LINE_IS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> route_q[line]);  // R5
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));  // R7
endmodule

// File: rtl/rtr_bus_decode.sv
module rtr_bus_decode
  import rtr_pkg::*;
#(
  parameter int unsigned NUM_CPUS  = 4,
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  input  logic                                req_write,
  input  logic [ADDR_W-1:0]                   req_addr,
  input  logic [1:0]                          req_size,
  input  logic [NUM_CPUS-1:0][NUM_LINES-1:0]  mask_q,
  input  logic [NUM_CPUS-1:0][NUM_LINES-1:0]  route_q,
  input  logic [NUM_LINES-1:0]                pend_q,
  output logic [NUM_CPUS-1:0]                 mask_we,
  output logic                                resp_valid,
  output logic                                resp_err,
  output logic [NUM_LINES-1:0]                resp_rdata
);
  localparam int unsigned IDX_W = ADDR_W - IDX_SHIFT;
  localparam logic [IDX_W-1:0] ROUTE_BASE = IDX_W'(NUM_CPUS);
  localparam logic [IDX_W-1:0] PEND_IDX   = IDX_W'(2 * NUM_CPUS);

  logic [IDX_W-1:0]     idx;
  logic                 size_ok;
  logic                 is_mask;
  logic                 is_route;
  logic                 is_pend;
  logic                 err_d;
  logic [NUM_LINES-1:0] rd_sel;
  logic [NUM_LINES-1:0] rdata_d;

  always_comb begin
    idx      = req_addr[ADDR_W-1:IDX_SHIFT];
    size_ok  = (acc_size_e'(req_size) == SZ_DOUBLE);
    is_mask  = (idx < ROUTE_BASE);
    is_route = (idx >= ROUTE_BASE) && (idx < PEND_IDX);
    is_pend  = (idx == PEND_IDX);
    err_d    = !size_ok || !(is_mask || is_route || is_pend) ||
               (req_write && (is_route || is_pend));

    rd_sel = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (idx == IDX_W'(c))            rd_sel = mask_q[c];
      if (idx == IDX_W'(NUM_CPUS + c)) rd_sel = route_q[c];
    end
    if (is_pend) rd_sel = pend_q;

    rdata_d = (req_valid && !req_write && !err_d) ? rd_sel : '0;

    for (int c = 0; c < NUM_CPUS; c++) begin
      mask_we[c] = req_valid && req_write && size_ok && (idx == IDX_W'(c));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_err   <= req_valid && err_d;
      resp_rdata <= rdata_d;
    end
  end

  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);  // R11
  AST_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);  // R11
  AST_RO_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && (idx >= ROUTE_BASE) && (idx <= PEND_IDX)) |=> resp_err);  // R8
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> (resp_rdata == '0));  // R9
  AST_NO_WE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !size_ok |-> (mask_we == '0));  // R9
endmodule

// File: rtl/dev_irq_router.sv
module dev_irq_router #(
  parameter int unsigned NUM_CPUS  = 4,
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_LINES-1:0]         dev_set,
  input  logic [NUM_LINES-1:0]         dev_clr,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [1:0]                   req_size,
  input  logic [NUM_LINES-1:0]         req_wdata,
  output logic                         resp_valid,
  output logic                         resp_err,
  output logic [NUM_LINES-1:0]         resp_rdata,
  output logic [NUM_CPUS-1:0]          cpu_irq,
  output logic [NUM_CPUS*LINE_W-1:0]   cpu_line
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  logic [NUM_LINES-1:0]               pend_d;
  logic [NUM_LINES-1:0]               pend_q;
  logic [NUM_CPUS-1:0][NUM_LINES-1:0] mask_q;
  logic [NUM_CPUS-1:0][NUM_LINES-1:0] route_q;
  logic [NUM_CPUS-1:0]                mask_we;

  rtr_pending_reg #(.NUM_LINES(NUM_LINES)) i_pend (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .dev_set (dev_set),
    .dev_clr (dev_clr),
    .pend_d  (pend_d),
    .pend_q  (pend_q)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    rtr_cpu_slice #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) i_slice (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .mask_we (mask_we[c]),
      .wdata   (req_wdata),
      .pend_d  (pend_d),
      .pend_q  (pend_q),
      .mask_q  (mask_q[c]),
      .route_q (route_q[c]),
      .irq     (cpu_irq[c]),
      .line    (cpu_line[c*LINE_W +: LINE_W])
    );
  end

  rtr_bus_decode #(.NUM_CPUS(NUM_CPUS), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) i_dec (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .mask_q     (mask_q),
    .route_q    (route_q),
    .pend_q     (pend_q),
    .mask_we    (mask_we),
    .resp_valid (resp_valid),
    .resp_err   (resp_err),
    .resp_rdata (resp_rdata)
  );
endmodule

// File: tb/test_dev_irq_router.sv
module test_dev_irq_router;
  logic        clk;
  logic        rst_n;
  logic [63:0] dev_set, dev_clr;
  logic        req_valid, req_write;
  logic [11:0] req_addr;
  logic [1:0]  req_size;
  logic [63:0] req_wdata;
  logic        resp_valid, resp_err;
  logic [63:0] resp_rdata;
  logic [3:0]  cpu_irq;
  logic [23:0] cpu_line;

  dev_irq_router i_dev_irq_router (
    .clk(clk), .rst_n(rst_n), .dev_set(dev_set), .dev_clr(dev_clr),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .resp_valid(resp_valid),
    .resp_err(resp_err), .resp_rdata(resp_rdata), .cpu_irq(cpu_irq),
    .cpu_line(cpu_line)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 0;

  logic [63:0] m_pend;
  logic [63:0] m_mask [4];
  logic [63:0] last_rdata;
  logic        last_err, last_valid, valid_after;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int lowest(input logic [63:0] v);
    for (int i = 0; i < 64; i++) if (v[i]) return i;
    return 0;
  endfunction

  // one operation: optional bus access plus device pulses in the same cycle
  task automatic op(input bit bus, input bit wr, input logic [11:0] a, input logic [1:0] sz,
                    input logic [63:0] wd, input logic [63:0] s, input logic [63:0] c);
    @(negedge clk);
    req_valid = bus; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    dev_set = s; dev_clr = c;
    @(posedge clk);
    @(negedge clk);
    last_valid = resp_valid; last_err = resp_err; last_rdata = resp_rdata;
    req_valid = 0; req_write = 0; dev_set = '0; dev_clr = '0;
    @(posedge clk);
    @(negedge clk);
    valid_after = resp_valid;
    m_pend = (m_pend & ~c) | s;
    if (bus && wr && sz == 2'd3 && (a >> 6) < 4) m_mask[a >> 6] = wd;
  endtask

  task automatic rd(input logic [11:0] a);
    op(1, 0, a, 2'd3, '0, '0, '0);
  endtask

  task automatic chk_outputs(input string req);
    for (int c = 0; c < 4; c++) begin
      logic [63:0] r;
      r = m_mask[c] & m_pend;
      chk(req, $sformatf("irq cpu%0d", c), {63'd0, cpu_irq[c]}, {63'd0, (r != 0)});
      chk(req, $sformatf("line cpu%0d", c), {58'd0, cpu_line[c*6 +: 6]}, 64'(lowest(r)));
    end
  endtask

  task automatic t_reset;
    chk("R1", "irq", {60'd0, cpu_irq}, 64'd0);
    chk("R1", "line", {40'd0, cpu_line}, 64'd0);
    chk("R1", "resp_valid", {63'd0, resp_valid}, 64'd0);
    for (int i = 0; i < 9; i++) begin
      rd(12'(i << 6));
      chk("R1", $sformatf("reg %0d", i), last_rdata, 64'd0);
    end
  endtask

  task automatic t_dev_events;
    op(0, 0, '0, 2'd3, '0, (64'd1 << 5) | (64'd1 << 40), '0);
    rd(12'h200);
    chk("R2", "pending after set", last_rdata, (64'd1 << 5) | (64'd1 << 40));
    op(0, 0, '0, 2'd3, '0, 64'd1 << 7, (64'd1 << 7) | (64'd1 << 5));
    rd(12'h200);
    chk("R2", "set wins, drop bit5", last_rdata, (64'd1 << 7) | (64'd1 << 40));
  endtask

  task automatic t_spurious;
    logic [3:0] irq_b;
    op(0, 0, '0, 2'd3, '0, '0, 64'd1 << 9);
    irq_b = cpu_irq;
    rd(12'h200);
    chk("R3", "pending after spurious drop", last_rdata, m_pend);
    chk("R3", "irq unchanged", {60'd0, cpu_irq}, {60'd0, irq_b});
  endtask

  task automatic t_route;
    op(1, 1, 12'h000, 2'd3, 64'd1 << 40, '0, '0);
    op(1, 1, 12'h080, 2'd3, (64'd1 << 63) | (64'd1 << 40) | (64'd1 << 7), '0, '0);
    chk_outputs("R5");
    chk("R5", "cpu2 line 7", {58'd0, cpu_line[17:12]}, 64'd7);
    rd(12'h180);
    chk("R4", "routed cpu2", last_rdata, (64'd1 << 40) | (64'd1 << 7));
    rd(12'h080);
    chk("R7", "mask cpu2 readback", last_rdata, (64'd1 << 63) | (64'd1 << 40) | (64'd1 << 7));
    op(0, 0, '0, 2'd3, '0, '0, 64'd1 << 7);
    chk_outputs("R5");
    chk("R5", "cpu2 moves to 40", {58'd0, cpu_line[17:12]}, 64'd40);
  endtask

  task automatic t_low_bits;
    op(1, 1, 12'h040, 2'd3, 64'hA5A5_0000_1234_5678, '0, '0);
    rd(12'h040 + 12'h18);
    chk("R6", "low addr bits ignored", last_rdata, 64'hA5A5_0000_1234_5678);
    rd(12'h17F);
    chk("R6", "routed cpu1 via offset", last_rdata, 64'hA5A5_0000_1234_5678 & m_pend);
  endtask

  task automatic t_ro_writes;
    logic [63:0] r2;
    r2 = m_mask[2] & m_pend;
    op(1, 1, 12'h180, 2'd3, 64'hFFFF, '0, '0);
    chk("R8", "err on routed write", {63'd0, last_err}, 64'd1);
    rd(12'h180);
    chk("R8", "routed unchanged", last_rdata, r2);
    op(1, 1, 12'h200, 2'd3, '1, '0, '0);
    chk("R8", "err on pending write", {63'd0, last_err}, 64'd1);
    rd(12'h200);
    chk("R8", "pending unchanged", last_rdata, m_pend);
    chk_outputs("R8");
  endtask

  task automatic t_bad_size;
    op(1, 1, 12'h0C0, 2'd2, '1, '0, '0);
    chk("R9", "err on narrow write", {63'd0, last_err}, 64'd1);
    rd(12'h0C0);
    chk("R9", "mask3 unchanged", last_rdata, 64'd0);
    chk("R9", "irq3 low", {63'd0, cpu_irq[3]}, 64'd0);
    op(1, 0, 12'h040, 2'd0, '0, '0, '0);
    chk("R9", "err on narrow read", {63'd0, last_err}, 64'd1);
    chk("R9", "narrow read data zero", last_rdata, 64'd0);
  endtask

  task automatic t_undef;
    rd(12'h240);
    chk("R10", "err idx 9", {63'd0, last_err}, 64'd1);
    chk("R10", "data idx 9", last_rdata, 64'd0);
    rd(12'hFC0);
    chk("R10", "err idx 63", {63'd0, last_err}, 64'd1);
    rd(12'h000);
    chk("R10", "legal read no err", {63'd0, last_err}, 64'd0);
  endtask

  task automatic t_resp_timing;
    rd(12'h000);
    chk("R11", "valid next cycle", {63'd0, last_valid}, 64'd1);
    chk("R11", "valid drops", {63'd0, valid_after}, 64'd0);
    op(1, 1, 12'h0C0, 2'd3, 64'd1 << 3, '0, '0);
    chk("R11", "write response", {63'd0, last_valid}, 64'd1);
    chk("R11", "write no data", last_rdata, 64'd0);
  endtask

  task automatic t_collision;
    op(1, 1, 12'h0C0, 2'd3, 64'd1 << 20, 64'd1 << 20, '0);
    chk("R4", "irq3 same-cycle enable+raise", {63'd0, cpu_irq[3]}, 64'd1);
    chk("R4", "line3 20", {58'd0, cpu_line[23:18]}, 64'd20);
    op(1, 1, 12'h000, 2'd3, 64'd1 << 30, 64'd1 << 30, 64'd1 << 40);
    chk_outputs("R4");
    rd(12'h100);
    chk("R4", "routed cpu0 after collision", last_rdata, 64'd1 << 30);
  endtask

  initial begin
    rst_n = 0; dev_set = '0; dev_clr = '0; req_valid = 0; req_write = 0;
    req_addr = '0; req_size = 2'd3; req_wdata = '0;
    m_pend = '0;
    for (int c = 0; c < 4; c++) m_mask[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset;
    t_dev_events;
    t_spurious;
    t_route;
    t_low_bits;
    t_ro_writes;
    t_bad_size;
    t_undef;
    t_resp_timing;
    t_collision;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule